// File: doc/BRIEF.md
# TMDS Channel Word Aligner and Deskew

This block sits behind the serial-to-parallel front end of a three-lane TMDS receiver. Each lane hands over one raw 10-bit word per pixel clock. The word holds ten consecutive serial bits, and bit 0 is the earliest. The character boundary inside that word is unknown, and the lanes can arrive up to one pixel period apart. Per lane, the block finds the rotation at which the transition-rich blanking tokens appear and locks to it. Once all three lanes are locked, it lines them up through a small circular buffer per lane, so that the three output words always come from the same character slot.

The search tries one rotation at a time. A rotation is accepted after eight back-to-back token hits. If nothing is accepted within 128 characters, the search moves to the next rotation. A lock is held through active video and is only given up for one of two reasons. The first is a run of blanking characters in which a token shows up at some other rotation but not at the locked one. The second is an explicit link reset. Line-up is taken on the first pixel that follows the end of a blanking run. From then on the outputs stream every cycle with a valid flag.

Top module: `tmds_word_aligner`

## Requirements
- R1: A lane locks only after 8 consecutive characters, taken at its current rotation, each equal to one of 10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011. A run of 7 followed by a non-token does not lock.
- R2: An unlocked lane tries rotation 0 first after reset and moves to the next rotation (9 wraps to 0) after 128 characters without locking. A lane therefore locks for any bit offset 0..10 of its stream within a long blanking run.
- R3: With rotation r, the aligned character is bits r..r+9 of the 20-bit concatenation {current raw word, previous raw word}. Serial bit 0 of each character is output bit 0.
- R4: Once locked, a lane stays locked through active video made of characters that contain no token at any rotation.
- R5: A locked lane drops lock after 4 consecutive characters that match a token at some other rotation but not at the locked one. Any other character clears that count.
- R6: link_reset clears every lane lock, the valid flag and the output words at the next clock edge, and restarts the search at rotation 0.
- R7: all_locked is high exactly when all three bits of ch_locked are high.
- R8: With all lanes locked, output starts with the first non-token character after a blanking run on every lane. After that, each cycle's three output words belong to one character slot, even when the lane streams are delayed by different amounts of 0 to 10 bits. word_valid stays high while all lanes remain locked.
- R9: After reset, and whenever word_valid is low, ch_locked, all_locked and the output words are zero, or the output words alone are zero, as applies. word_valid is low in any cycle that follows a cycle with all_locked low.
- R10: A stream that never carries tokens never produces a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | Synchronous request to drop all locks and restart the search |
| ch0_raw | input | 10 | Lane 0 raw word, bit 0 earliest |
| ch1_raw | input | 10 | Lane 1 raw word, bit 0 earliest |
| ch2_raw | input | 10 | Lane 2 raw word, bit 0 earliest |
| ch0_word | output | 10 | Lane 0 aligned, deskewed character |
| ch1_word | output | 10 | Lane 1 aligned, deskewed character |
| ch2_word | output | 10 | Lane 2 aligned, deskewed character |
| word_valid | output | 1 | Output words carry a lined-up slot |
| ch_locked | output | 3 | Per-lane lock flag, bit n for lane n |
| all_locked | output | 1 | All lanes locked |

## Verification
The bench sweeps every bit offset from 0 to 10 across the three lanes. Offsets 0 and 10 land on the same rotation but one whole character apart, so a deskew that trusted rotation alone would emit slots from two different characters and the slot-by-slot compare catches it. A token run of seven must not lock; an off-by-one hit counter would lock during that run. A mid-stream bit slip on one lane must cost that lane its lock within the next blanking run while the other lanes hold theirs; a design that never checks other rotations would keep emitting shifted garbage. A data-only stream and a link reset must both leave the lock flags and outputs at zero.

// File: rtl/tmds_word_aligner.sv
module tmds_word_aligner #(
  parameter int HITS   = 8,
  parameter int DWELL  = 128,
  parameter int MISSES = 4,
  parameter int DEPTH  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_reset,
  input  logic [9:0] ch0_raw,
  input  logic [9:0] ch1_raw,
  input  logic [9:0] ch2_raw,
  output logic [9:0] ch0_word,
  output logic [9:0] ch1_word,
  output logic [9:0] ch2_word,
  output logic       word_valid,
  output logic [2:0] ch_locked,
  output logic       all_locked
);
  localparam int W   = 10;
  localparam int NCH = 3;
  localparam int HW  = $clog2(HITS);
  localparam int TW  = $clog2(DWELL);
  localparam int MW  = $clog2(MISSES);
  localparam int AW  = $clog2(DEPTH);
  localparam logic [HW-1:0] HIT_LAST  = HW'(HITS - 1);
  localparam logic [TW-1:0] DWELL_END = TW'(DWELL - 1);
  localparam logic [MW-1:0] MISS_END  = MW'(MISSES - 1);
  localparam logic [3:0]    ROT_END   = 4'(W - 1);

  function automatic logic is_tok(input logic [W-1:0] v);
    return v == 10'b1101010100 || v == 10'b0010101011 ||
           v == 10'b0101010100 || v == 10'b1010101011;
  endfunction

  logic [NCH-1:0][W-1:0] raw_in, word_out;
  logic [NCH-1:0]        seen;
  logic                  running, go;

  assign raw_in     = {ch2_raw, ch1_raw, ch0_raw};
  assign ch0_word   = word_out[0];
  assign ch1_word   = word_out[1];
  assign ch2_word   = word_out[2];
  assign all_locked = &ch_locked;
  assign go         = all_locked & ~link_reset & (running | &seen);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [W-1:0]   prev, aligned, out_q;
    logic [2*W-1:0] win;
    logic [3:0]     rot;
    logic [HW-1:0]  hits;
    logic [TW-1:0]  dwell;
    logic [MW-1:0]  bad;
    logic [AW-1:0]  wp, rp, mark, rptr;
    logic           lk, tok_q, hit, any_rot, stray, run_end, seen_q;
    logic [W-1:0]   fifo [DEPTH];

    assign win     = {raw_in[c], prev};
    assign aligned = W'(win >> rot);
    assign hit     = is_tok(aligned);
    assign stray   = any_rot & ~hit;
    assign run_end = lk & tok_q & ~hit;
    assign rptr    = running ? rp : mark;

    always_comb begin
      any_rot = 1'b0;
      for (int r = 0; r < W; r++)
        if (is_tok(win[r +: W])) any_rot = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev <= '0; tok_q <= 1'b0; lk <= 1'b0; rot <= '0;
        hits <= '0; dwell <= '0; bad <= '0;
      end else begin
        prev  <= raw_in[c];
        tok_q <= hit;
        if (link_reset) begin
          lk <= 1'b0; rot <= '0; hits <= '0; dwell <= '0; bad <= '0;
        end else if (!lk) begin
          if (hit && hits == HIT_LAST) begin
            lk <= 1'b1; hits <= '0; dwell <= '0; bad <= '0;
          end else if (dwell == DWELL_END) begin
            dwell <= '0; hits <= '0;
            rot   <= (rot == ROT_END) ? 4'd0 : rot + 4'd1;
          end else begin
            dwell <= dwell + 1'b1;
            hits  <= hit ? hits + 1'b1 : '0;
          end
        end else if (stray) begin
          if (bad == MISS_END) begin
            lk <= 1'b0; bad <= '0; hits <= '0; dwell <= '0;
          end else begin
            bad <= bad + 1'b1;
          end
        end else begin
          bad <= '0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (lk) fifo[wp] <= aligned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; mark <= '0; seen_q <= 1'b0; out_q <= '0;
      end else begin
        if (lk) wp <= wp + 1'b1;
        if (link_reset || !lk || !all_locked) seen_q <= 1'b0;
        else if (run_end && !seen_q) begin
          seen_q <= 1'b1;
          mark   <= wp;
        end
        if (go) begin
          out_q <= fifo[rptr];
          rp    <= rptr + 1'b1;
        end else begin
          out_q <= '0;
        end
      end
    end

    assign ch_locked[c] = lk;
    assign seen[c]      = seen_q;
    assign word_out[c]  = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      running    <= go;
      word_valid <= go;
    end
  end
endmodule

// File: rtl/tmds_word_aligner_chk.sv
module tmds_word_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_reset,
  input logic       word_valid,
  input logic       all_locked,
  input logic [2:0] ch_locked,
  input logic [9:0] w0,
  input logic [9:0] w1,
  input logic [9:0] w2
);
  p_all_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
    all_locked == (&ch_locked));

  p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset |=> (ch_locked == 3'b000) && !word_valid);

  p_valid_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !all_locked |=> !word_valid);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> (w0 == 10'd0 && w1 == 10'd0 && w2 == 10'd0));

  p_start_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(all_locked));

  for (genvar i = 0; i < 3; i++) begin : g_ch
    p_lock_not_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_locked[i]) |-> !$past(link_reset));
  end
endmodule

bind tmds_word_aligner tmds_word_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .word_valid(word_valid),
  .all_locked(all_locked), .ch_locked(ch_locked),
  .w0(ch0_word), .w1(ch1_word), .w2(ch2_word)
);

// File: tb/tmds_word_aligner_tb.sv
module tmds_word_aligner_tb;
  logic clk = 1'b0, rst_n = 1'b0, link_reset = 1'b0;
  logic [9:0] r0 = '0, r1 = '0, r2 = '0;
  logic [9:0] w0, w1, w2;
  logic word_valid, all_locked;
  logic [2:0] ch_locked;

  localparam logic [9:0] TK = 10'b1101010100;

  int checks = 0, errors = 0;
  int mode = 0, k = 0;
  int sk [3] = '{0, 0, 0};
  int ej = 0, mon_cnt = 0;
  bit mon_en = 0, done = 0;

  always #5 clk = ~clk;

  tmds_word_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .link_reset(link_reset),
    .ch0_raw(r0), .ch1_raw(r1), .ch2_raw(r2),
    .ch0_word(w0), .ch1_word(w1), .ch2_word(w2),
    .word_valid(word_valid), .ch_locked(ch_locked), .all_locked(all_locked)
  );

  function automatic logic [9:0] dat(int c, int j);
    int i;
    i = (j * 7 + c * 13) % 64;
    return {i[5], i[4], {3{i[3]}}, i[2], i[1], {3{i[0]}}};
  endfunction

  function automatic logic [9:0] chr(int c, int j);
    case (mode)
      0: return (j < 1600) ? TK : (((j - 1600) % 200) < 60 ? dat(c, j) : TK);
      1: return dat(c, j);
      default: return (j < 600) ? (((j % 30) < 7) ? TK : dat(c, j)) : TK;
    endcase
  endfunction

  function automatic logic [9:0] rawword(int c, int kk);
    logic [9:0] v, ch;
    int pos;
    for (int b = 0; b < 10; b++) begin
      pos  = 10 * kk - sk[c] + b;
      ch   = chr(c, pos / 10);
      v[b] = ch[pos % 10];
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      k++;
      r0 = rawword(0, k); r1 = rawword(1, k); r2 = rawword(2, k);
    end
  endtask

  task automatic start(int m, int a, int b, int c);
    mode = m; sk[0] = a; sk[1] = b; sk[2] = c; k = 0;
    mon_en = 0; mon_cnt = 0; ej = 1600;
    link_reset = 1'b1; step(2); link_reset = 1'b0;
    mon_en = (m == 0);
  endtask

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (word_valid) begin
        logic [9:0] got [3];
        got[0] = w0; got[1] = w1; got[2] = w2;
        for (int c = 0; c < 3; c++)
          chk(got[c] == chr(c, ej), "R8", $sformatf("ch%0d slot %0d", c, ej),
              got[c], chr(c, ej));
        ej++;
        mon_cnt++;
      end else if (mon_cnt > 0) begin
        chk(0, "R8", "valid dropped while locked", 0, 1);
        mon_cnt = 0;
      end
    end
  end

  task automatic sweep(int a, int b, int c);
    start(0, a, b, c);
    step(1648);
    @(negedge clk);
    chk(ch_locked == 3'b111, "R4", $sformatf("locked in video %0d/%0d/%0d", a, b, c), ch_locked, 7);
    chk(all_locked == 1'b1, "R7", "all_locked with every lane locked", all_locked, 1);
    step(750);
    @(negedge clk);
    chk(mon_cnt > 700, "R2", $sformatf("aligned slots for offsets %0d/%0d/%0d", a, b, c), mon_cnt, 700);
    chk(ch_locked == 3'b111, "R3", "lock held to end of sweep", ch_locked, 7);
  endtask

  initial begin
    step(3);
    @(negedge clk);
    chk(ch_locked == 3'b000 && !all_locked, "R9", "locks in reset", ch_locked, 0);
    chk(!word_valid && w0 == 0 && w1 == 0 && w2 == 0, "R9", "outputs in reset", {w2, w1, w0}, 0);
    rst_n = 1'b1;

    sweep(0, 5, 10);
    sweep(1, 2, 3);
    sweep(4, 6, 9);
    sweep(7, 8, 0);
    sweep(9, 3, 6);
    sweep(10, 10, 1);

    // R5: bit slip on lane 1 during video, lost at next blanking
    start(0, 2, 4, 6);
    step(1608);
    @(negedge clk);
    chk(ch_locked == 3'b111, "R5", "locked before slip", ch_locked, 7);
    mon_en = 0;
    sk[1] = 5;
    step(70);
    @(negedge clk);
    chk(ch_locked == 3'b101, "R5", "slipped lane unlocked, others held", ch_locked, 5);
    chk(!all_locked, "R7", "all_locked low after slip", all_locked, 0);
    chk(!word_valid && w1 == 0, "R9", "outputs idle after slip", word_valid, 0);

    // R6: link reset
    start(0, 0, 0, 0);
    step(1700);
    @(negedge clk);
    chk(ch_locked == 3'b111 && word_valid, "R6", "locked before link reset", ch_locked, 7);
    mon_en = 0;
    link_reset = 1'b1; step(1); link_reset = 1'b0; step(1);
    @(negedge clk);
    chk(ch_locked == 3'b000, "R6", "locks after link reset", ch_locked, 0);
    chk(!word_valid && w0 == 0 && w2 == 0, "R6", "outputs after link reset", word_valid, 0);

    // R10: no tokens, no lock
    start(1, 0, 3, 7);
    step(1500);
    @(negedge clk);
    chk(ch_locked == 3'b000, "R10", "data-only stream", ch_locked, 0);
    chk(!word_valid, "R10", "valid on data-only stream", word_valid, 0);

    // R1: runs of seven tokens do not lock, a long run does
    start(2, 0, 0, 0);
    step(598);
    @(negedge clk);
    chk(ch_locked == 3'b000, "R1", "runs of seven tokens", ch_locked, 0);
    step(1400);
    @(negedge clk);
    chk(ch_locked == 3'b111, "R1", "long token run", ch_locked, 7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule